// File: doc/BRIEF.md
# Dual-Mode Control Word Loader

This block is the programming front end of a numerically controlled oscillator. A host writes a 40-bit setting through two strobes that are asynchronous to the reference clock: a word-load strobe and an update strobe. Both strobes are brought into the reference clock domain, and each one acts on its rising edge.

The host first fills a staged input register. It can do so as five bytes on an 8-bit bus, or as 40 single bits taken from the top bus line. An update edge then copies the staged word into the active register that drives the oscillator. The active register holds a 32-bit frequency word, a 5-bit phase word, a power-down bit and a 2-bit control field.

The loader starts in byte mode. A special control value switches it to bit mode, and it stays there until reset. Transfers that carry a reserved control value are refused, and a flag reports the refusal.

Top module: `ctrl_word_loader`

## Requirements
- R1: In byte mode the slots fill in this order. Slot 0 holds phase[4:0] in bus bits 7..3, power-down in bit 2 and control[1:0] in bits 1..0. Slots 1 to 4 carry the frequency word, most significant byte first. The values become visible on the outputs after the next update.
- R2: Once five bytes have been taken, further word-load edges change nothing until an update or a reset.
- R3: An update edge copies the staged word to the outputs and sends the byte pointer back to slot 0, so a partial load afterwards rewrites only the leading slots.
- R4: In bit mode, each word-load edge shifts bus bit 7 in, and the other bus bits are ignored. After 40 edges, the first bit sent is frequency bit 0. The bits then run as frequency bits 0..31, control bits at positions 32..33, power-down at 34 and phase bits 0..4 at 35..39.
- R5: In byte mode, an update whose staged slot 0 has its low three bits equal to 011 switches the loader to bit mode, and serialMode goes to 1. The same update is applied normally, with control field 11. Bit mode lasts until reset.
- R6: Reset clears frequency, phase, power-down, control, serialMode and rejectFlag, and returns the pointer to slot 0. It keeps the staged word, so an update straight after reset shows what was loaded before it.
- R7: An update is refused, leaving all outputs unchanged and setting rejectFlag to 1, when its control field is reserved. In byte mode the reserved values are 01 and 10. In bit mode any nonzero value is reserved. An accepted update clears rejectFlag.
- R8: When a word-load edge and an update edge reach the reference domain in the same cycle, the update wins. The word transferred is the staged value from before that cycle, and the byte or bit is discarded.
- R9: Each rising edge of a strobe acts exactly once, however long the strobe stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high master reset |
| wordStb | input | 1 | Asynchronous word-load strobe |
| updStb | input | 1 | Asynchronous update strobe |
| busData | input | 8 | Byte bus; bit 7 carries serial data |
| freqWord | output | 32 | Active frequency word |
| phaseWord | output | 5 | Active phase word |
| powerDown | output | 1 | Active power-down bit |
| ctrlBits | output | 2 | Active control field |
| serialMode | output | 1 | 1 while bit mode is selected |
| rejectFlag | output | 1 | 1 after a refused transfer |

## Verification
A word-load edge and an update edge can land in the same reference cycle. The bench provokes this by raising both strobes in the same instant, while one extra byte is already staged so that the staged word differs from the active one. A correct result has two parts. The outputs must take the staged word from before that cycle, with the new bus byte absent. A following single-byte load and update must then show the pointer back at slot 0 and slot 1 untouched.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  parameter int FREQ_W  = 32;
  parameter int PHASE_W = 5;
  parameter int CTRL_W  = 2;
  parameter int BUS_W   = 8;

  localparam int WORD_W    = FREQ_W + CTRL_W + 1 + PHASE_W;
  localparam int SLOTS     = WORD_W / BUS_W;
  localparam int PTR_W     = $clog2(SLOTS + 1);
  localparam int CTRL_LSB  = FREQ_W;
  localparam int PD_BIT    = FREQ_W + CTRL_W;
  localparam int PHASE_LSB = PD_BIT + 1;
  localparam int HDR_W     = CTRL_W + 1;

  typedef struct packed {
    logic             loadByte;
    logic [PTR_W-1:0] slot;
    logic             shiftBit;
    logic             commit;
    logic             reject;
  } strobes_t;
endpackage

// File: rtl/cwl_edge_sync.sv
module cwl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prevLvl;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prevLvl <= 1'b0;
    else     prevLvl <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prevLvl;

  // R9: a held strobe yields a single action pulse
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/cwl_ctrl.sv
module cwl_ctrl
  import cwl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrRise,
  input  logic             updRise,
  input  logic [HDR_W-1:0] stagedHdr,
  output strobes_t         stb,
  output logic             serialMode
);
  logic [PTR_W-1:0] ptr;
  logic             resvCode;
  logic             enterSer;
  logic [CTRL_W-1:0] ctrlPart;

  assign ctrlPart = stagedHdr[CTRL_W-1:0];

  always_comb begin
    if (serialMode) resvCode = (ctrlPart != '0);
    else            resvCode = (ctrlPart == CTRL_W'(1)) || (ctrlPart == CTRL_W'(2));
  end

  assign enterSer = updRise && !serialMode && (stagedHdr == HDR_W'(3'b011));

  always_comb begin
    stb = '0;
    if (updRise) begin
      stb.commit = !resvCode;
      stb.reject = resvCode;
    end else if (wrRise) begin
      if (serialMode) begin
        stb.shiftBit = 1'b1;
      end else if (ptr < PTR_W'(SLOTS)) begin
        stb.loadByte = 1'b1;
        stb.slot     = ptr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr        <= '0;
      serialMode <= 1'b0;
    end else begin
      if (updRise)           ptr <= '0;
      else if (stb.loadByte) ptr <= ptr + 1'b1;
      if (enterSer)          serialMode <= 1'b1;
    end
  end

  a_r2_ptr_limit: assert property (@(posedge clk) disable iff (rst)
    ptr <= PTR_W'(SLOTS));
  a_r2_full_ignored: assert property (@(posedge clk) disable iff (rst)
    (ptr == PTR_W'(SLOTS) && !updRise) |=> ptr == PTR_W'(SLOTS));
  a_r3_ptr_home: assert property (@(posedge clk) disable iff (rst)
    updRise |=> ptr == '0);
  a_r5_serial_sticky: assert property (@(posedge clk) disable iff (rst)
    serialMode |=> serialMode);
  a_r6_reset_parallel: assert property (@(posedge clk)
    rst |=> (!serialMode && ptr == '0));
endmodule

// File: rtl/cwl_data.sv
module cwl_data
  import cwl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [BUS_W-1:0]   busData,
  input  strobes_t           stb,
  output logic [HDR_W-1:0]   stagedHdr,
  output logic [FREQ_W-1:0]  freqWord,
  output logic [PHASE_W-1:0] phaseWord,
  output logic               powerDown,
  output logic [CTRL_W-1:0]  ctrlBits,
  output logic               rejectFlag
);
  logic [WORD_W-1:0] staged;

  // staged register is deliberately outside reset
  always_ff @(posedge clk) begin
    if (stb.shiftBit) begin
      staged <= {busData[BUS_W-1], staged[WORD_W-1:1]};
    end else if (stb.loadByte) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (stb.slot == PTR_W'(s))
          staged[WORD_W-1-s*BUS_W -: BUS_W] <= busData;
      end
    end
  end

  assign stagedHdr = staged[PD_BIT:CTRL_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      freqWord   <= '0;
      phaseWord  <= '0;
      powerDown  <= 1'b0;
      ctrlBits   <= '0;
      rejectFlag <= 1'b0;
    end else if (stb.commit) begin
      freqWord   <= staged[FREQ_W-1:0];
      phaseWord  <= staged[WORD_W-1:PHASE_LSB];
      powerDown  <= staged[PD_BIT];
      ctrlBits   <= staged[PD_BIT-1:CTRL_LSB];
      rejectFlag <= 1'b0;
    end else if (stb.reject) begin
      rejectFlag <= 1'b1;
    end
  end

  a_r6_reset_clears: assert property (@(posedge clk)
    rst |=> (freqWord == '0 && phaseWord == '0 && !powerDown && ctrlBits == '0 && !rejectFlag));
  a_r7_reject_holds: assert property (@(posedge clk) disable iff (rst)
    stb.reject |=> ($stable(freqWord) && $stable(phaseWord) && $stable(ctrlBits) && rejectFlag));
  a_r3_commit_copies: assert property (@(posedge clk) disable iff (rst)
    stb.commit |=> (freqWord == $past(staged[FREQ_W-1:0]) && !rejectFlag));
  a_r8_single_action: assert property (@(posedge clk) disable iff (rst)
    $countones({stb.commit, stb.reject, stb.loadByte, stb.shiftBit}) <= 1);
endmodule

// File: rtl/ctrl_word_loader.sv
module ctrl_word_loader
  import cwl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wordStb,
  input  logic               updStb,
  input  logic [BUS_W-1:0]   busData,
  output logic [FREQ_W-1:0]  freqWord,
  output logic [PHASE_W-1:0] phaseWord,
  output logic               powerDown,
  output logic [CTRL_W-1:0]  ctrlBits,
  output logic               serialMode,
  output logic               rejectFlag
);
  logic             wrRise;
  logic             updRise;
  logic [HDR_W-1:0] stagedHdr;
  strobes_t         stb;

  cwl_edge_sync #(.STAGES(SYNC_STAGES)) uWrSync (
    .clk(clk), .rst(rst), .asyncIn(wordStb), .rise(wrRise));

  cwl_edge_sync #(.STAGES(SYNC_STAGES)) uUpdSync (
    .clk(clk), .rst(rst), .asyncIn(updStb), .rise(updRise));

  cwl_ctrl uCtrl (
    .clk(clk), .rst(rst), .wrRise(wrRise), .updRise(updRise),
    .stagedHdr(stagedHdr), .stb(stb), .serialMode(serialMode));

  cwl_data uData (
    .clk(clk), .rst(rst), .busData(busData), .stb(stb),
    .stagedHdr(stagedHdr), .freqWord(freqWord), .phaseWord(phaseWord),
    .powerDown(powerDown), .ctrlBits(ctrlBits), .rejectFlag(rejectFlag));
endmodule

// File: tb/ctrl_word_loader_test.sv
`timescale 1ns/1ps
module ctrl_word_loader_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wordStb = 1'b0;
  logic        updStb = 1'b0;
  logic [7:0]  busData = 8'h00;
  logic [31:0] freqWord;
  logic [4:0]  phaseWord;
  logic        powerDown;
  logic [1:0]  ctrlBits;
  logic        serialMode;
  logic        rejectFlag;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] f;
    logic [4:0]  p;
    logic        pd;
    logic [1:0]  c;
    logic        ser;
    logic        rj;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  ctrl_word_loader uut (
    .clk(clk), .rst(rst), .wordStb(wordStb), .updStb(updStb), .busData(busData),
    .freqWord(freqWord), .phaseWord(phaseWord), .powerDown(powerDown),
    .ctrlBits(ctrlBits), .serialMode(serialMode), .rejectFlag(rejectFlag));

  // monitor: pops expectations and compares against the ports
  always @(negedge clk) begin : monitor
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      nChecks++;
      if (freqWord !== e.f || phaseWord !== e.p || powerDown !== e.pd ||
          ctrlBits !== e.c || serialMode !== e.ser || rejectFlag !== e.rj) begin
        nFail++;
        $display("FAIL %s: got f=%h p=%0d pd=%0b c=%0d ser=%0b rj=%0b expected f=%h p=%0d pd=%0b c=%0d ser=%0b rj=%0b",
                 e.tag, freqWord, phaseWord, powerDown, ctrlBits, serialMode, rejectFlag,
                 e.f, e.p, e.pd, e.c, e.ser, e.rj);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadByte(logic [7:0] b);
    busData = b;
    tick(2);
    wordStb = 1'b1;
    tick(4);
    wordStb = 1'b0;
    tick(3);
  endtask

  task automatic doUpdate();
    updStb = 1'b1;
    tick(4);
    updStb = 1'b0;
    tick(4);
  endtask

  task automatic bothStrobes(logic [7:0] b);
    busData = b;
    tick(2);
    wordStb = 1'b1;
    updStb  = 1'b1;
    tick(4);
    wordStb = 1'b0;
    updStb  = 1'b0;
    tick(4);
  endtask

  task automatic doReset();
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(2);
  endtask

  task automatic loadFive(logic [7:0] b0, logic [31:0] f);
    loadByte(b0);
    loadByte(f[31:24]);
    loadByte(f[23:16]);
    loadByte(f[15:8]);
    loadByte(f[7:0]);
  endtask

  task automatic serialWord(logic [39:0] w);
    for (int i = 0; i < 40; i++) loadByte({w[i], 7'h55});
  endtask

  task automatic expectOut(logic [31:0] f, logic [4:0] p, logic pd, logic [1:0] c,
                           logic ser, logic rj, string tag);
    exp_t e;
    e.f = f; e.p = p; e.pd = pd; e.c = c; e.ser = ser; e.rj = rj; e.tag = tag;
    q.push_back(e);
    while (q.size() != 0) @(negedge clk);
    tick(1);
  endtask

  initial begin : driver
    tick(5);
    rst = 1'b0;
    tick(2);
    expectOut(32'h0, 5'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R6 reset state");

    // R1: two byte-mode words
    loadFive(8'hA8, 32'h12345678);
    doUpdate();
    expectOut(32'h12345678, 5'd21, 1'b0, 2'd0, 1'b0, 1'b0, "R1 byte order A");
    loadFive(8'h5C, 32'hDEADBEEF);
    doUpdate();
    expectOut(32'hDEADBEEF, 5'd11, 1'b1, 2'd0, 1'b0, 1'b0, "R1 byte order B");

    // R2: extra loads after five are ignored; R9 held strobe loads once
    loadFive(8'h00, 32'h01020304);
    loadByte(8'hFF);
    loadByte(8'hFF);
    doUpdate();
    expectOut(32'h01020304, 5'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R2/R9 overflow ignored");

    // R3: partial load after update restarts at slot 0
    loadByte(8'h10);
    loadByte(8'hAA);
    doUpdate();
    expectOut(32'hAA020304, 5'd2, 1'b0, 2'd0, 1'b0, 1'b0, "R3 partial load");
    loadByte(8'h18);
    doUpdate();
    expectOut(32'hAA020304, 5'd3, 1'b0, 2'd0, 1'b0, 1'b0, "R3 pointer home");

    // R8: simultaneous strobes, update wins and byte is dropped
    loadByte(8'h28);
    bothStrobes(8'hF8);
    expectOut(32'hAA020304, 5'd5, 1'b0, 2'd0, 1'b0, 1'b0, "R8 same-cycle transfer");
    loadByte(8'h20);
    doUpdate();
    expectOut(32'hAA020304, 5'd4, 1'b0, 2'd0, 1'b0, 1'b0, "R8 byte discarded");

    // R7: reserved codes in byte mode
    loadByte(8'h09);
    doUpdate();
    expectOut(32'hAA020304, 5'd4, 1'b0, 2'd0, 1'b0, 1'b1, "R7 code 01 refused");
    loadByte(8'h0A);
    doUpdate();
    expectOut(32'hAA020304, 5'd4, 1'b0, 2'd0, 1'b0, 1'b1, "R7 code 10 refused");
    loadByte(8'h08);
    doUpdate();
    expectOut(32'hAA020304, 5'd1, 1'b0, 2'd0, 1'b0, 1'b0, "R7 accepted clears flag");

    // R6: reset keeps the staged word
    loadFive(8'h30, 32'h11223344);
    doReset();
    expectOut(32'h0, 5'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R6 reset clears outputs");
    doUpdate();
    expectOut(32'h11223344, 5'd6, 1'b0, 2'd0, 1'b0, 1'b0, "R6 staged kept");

    // R5: enter bit mode
    loadByte(8'h03);
    doUpdate();
    expectOut(32'h11223344, 5'd0, 1'b0, 2'd3, 1'b1, 1'b0, "R5 serial entry");

    // R4: serial word, phase 19, pd 1, ctrl 0
    serialWord({5'd19, 1'b1, 2'b00, 32'h0F1E2D3C});
    doUpdate();
    expectOut(32'h0F1E2D3C, 5'd19, 1'b1, 2'd0, 1'b1, 1'b0, "R4 serial order");

    // R7: reserved control in bit mode
    serialWord({5'd0, 1'b0, 2'b01, 32'h01234567});
    doUpdate();
    expectOut(32'h0F1E2D3C, 5'd19, 1'b1, 2'd0, 1'b1, 1'b1, "R7 serial reserved");

    // R6/R5: reset returns to byte mode
    doReset();
    expectOut(32'h0, 5'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R6 reset leaves bit mode");
    loadByte(8'h48);
    doUpdate();
    expectOut(32'h01234567, 5'd9, 1'b0, 2'd0, 1'b0, 1'b0, "R6 byte mode after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog (all requirements): got 150000 cycles, expected completion sooner");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule